// File: doc/BRIEF.md
# Pipeline Register File with Forwarding and Jump-Target Read

This block holds the general-purpose registers of a five-stage in-order pipeline. The decode stage reads two operands from it, and a third read port gives the fetch logic the target address for register-indirect jumps. One write port, driven by the write-back stage, updates a register on the rising clock edge. The write-back value is either the ALU result or the word loaded from data memory, chosen by a select input.

All reads are combinational. When a read index matches the register being written back in the same cycle, the read returns the value that is about to be written, not the stale stored one. The jump-target port has one more path. A register jump can take the ALU result still held in the execute/memory pipeline register, so it does not have to wait two cycles for that result to reach write-back. Reset gives two registers fixed non-zero values: the link register gets a recognisable marker, and the stack register gets the memory size. Every other register resets to zero. Register zero is an ordinary writable register here, because hardwiring it is left to the surrounding pipeline.

Top module: `bypass_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register is set to zero, except index 31, which becomes 0xDEADBEEF, and index 29, which becomes the `MEM_SIZE` parameter (default 0x00010000).
- R2: When `wb_we` is 1 at a rising edge, register `wb_idx` takes the write-back value. Index 0 is written like any other register. Other registers keep their contents.
- R3: The write-back value is `wb_load` when `wb_sel_load` is 1, and `wb_alu` when `wb_sel_load` is 0.
- R4: When `wb_we` is 0, no register changes, whatever is on `wb_idx` and the data inputs.
- R5: When `wb_we` is 1 and `rs_idx` equals `wb_idx`, `rs_data` gives the write-back value in that same cycle.
- R6: When `wb_we` is 1 and `rt_idx` equals `wb_idx`, `rt_data` gives the write-back value in that same cycle.
- R7: When `wb_we` is 1, `jr_idx` equals `wb_idx` and the memory-stage path does not match, `jr_data` gives the write-back value in that same cycle.
- R8: When `mem_fwd_en` is 1 and `jr_idx` equals `mem_idx`, `jr_data` gives `mem_alu`.
- R9: When the memory-stage path and the write-back path both match `jr_idx`, `jr_data` gives `mem_alu`, because it is the younger value.
- R10: The memory-stage path never affects `rs_data` or `rt_data`.
- R11: Reads are combinational. A change of a read index shows on its data output without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wb_we | input | 1 | Write-back enable |
| wb_idx | input | 5 | Write-back destination index |
| wb_sel_load | input | 1 | 1 selects load data, 0 selects ALU result |
| wb_alu | input | 32 | ALU result from the memory/write-back register |
| wb_load | input | 32 | Loaded word from the memory/write-back register |
| mem_fwd_en | input | 1 | Memory-stage ALU result is valid for forwarding |
| mem_idx | input | 5 | Destination index of the memory-stage result |
| mem_alu | input | 32 | ALU result held in the execute/memory register |
| rs_idx | input | 5 | First operand index |
| rt_idx | input | 5 | Second operand index |
| jr_idx | input | 5 | Jump-target register index |
| rs_data | output | 32 | First operand value |
| rt_data | output | 32 | Second operand value |
| jr_data | output | 32 | Jump-target value |

## Verification
The bench writes every register while reading that same index on all three ports in the same cycle. A design without the same-cycle path would return the old contents, so the bypass and the write select are both checked at every index, including zero. The reset values of indices 29 and 31 are read back individually, so a swapped or missing initial value shows up. The jump port is then driven with both forwarding sources matching at once: a design that gives write-back priority would return the older value. Disabled writes and the memory path are also aimed at the operand ports, which would change if the extra path leaked onto them.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Value a register takes at reset, given its index and the configured specials.
  function automatic logic [31:0] rf_init_word(
    input int          idx,
    input int          link_idx,
    input logic [31:0] link_val,
    input int          stack_idx,
    input logic [31:0] stack_val
  );
    if (idx == link_idx)       return link_val;
    else if (idx == stack_idx) return stack_val;
    else                       return '0;
  endfunction
endpackage

// File: rtl/rf_wb_mux.sv
module rf_wb_mux #(
  parameter int DATA_W = 32
) (
  input  logic              sel_load,
  input  logic [DATA_W-1:0] alu_val,
  input  logic [DATA_W-1:0] load_val,
  output logic [DATA_W-1:0] wb_val
);
  always_comb begin
    wb_val = sel_load ? load_val : alu_val;
  end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
  import rf_pkg::*;
#(
  parameter int          NUM_REGS  = 32,
  parameter int          DATA_W    = 32,
  parameter int          LINK_IDX  = 31,
  parameter logic [31:0] LINK_RST  = 32'hDEADBEEF,
  parameter int          STACK_IDX = 29,
  parameter logic [31:0] MEM_SIZE  = 32'h0001_0000,
  localparam int         IDX_W     = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [IDX_W-1:0]           widx,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NUM_REGS*DATA_W-1:0] flat_q
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [31:0] INIT32 = rf_init_word(g, LINK_IDX, LINK_RST, STACK_IDX, MEM_SIZE);
    localparam logic [DATA_W-1:0] INIT = INIT32[DATA_W-1:0];
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= INIT;
      else if (we && (widx == IDX_W'(g)))
        q <= wdata;
    end
    assign flat_q[g*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int  NUM_REGS = 32,
  parameter int  DATA_W   = 32,
  localparam int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS*DATA_W-1:0] flat_q,
  input  logic [IDX_W-1:0]           ridx,
  input  logic                       wb_we,
  input  logic [IDX_W-1:0]           wb_idx,
  input  logic [DATA_W-1:0]          wb_val,
  input  logic                       fwd_hit,
  input  logic [DATA_W-1:0]          fwd_val,
  output logic [DATA_W-1:0]          rdata
);
  logic [DATA_W-1:0] stored;
  always_comb begin
    stored = flat_q[ridx*DATA_W +: DATA_W];
    if (fwd_hit)
      rdata = fwd_val;
    else if (wb_we && (wb_idx == ridx))
      rdata = wb_val;
    else
      rdata = stored;
  end
endmodule

// File: rtl/bypass_regfile.sv
module bypass_regfile #(
  parameter int          NUM_REGS  = 32,
  parameter int          DATA_W    = 32,
  parameter int          LINK_IDX  = 31,
  parameter logic [31:0] LINK_RST  = 32'hDEADBEEF,
  parameter int          STACK_IDX = 29,
  parameter logic [31:0] MEM_SIZE  = 32'h0001_0000,
  localparam int         IDX_W     = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_we,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic              wb_sel_load,
  input  logic [DATA_W-1:0] wb_alu,
  input  logic [DATA_W-1:0] wb_load,
  input  logic              mem_fwd_en,
  input  logic [IDX_W-1:0]  mem_idx,
  input  logic [DATA_W-1:0] mem_alu,
  input  logic [IDX_W-1:0]  rs_idx,
  input  logic [IDX_W-1:0]  rt_idx,
  input  logic [IDX_W-1:0]  jr_idx,
  output logic [DATA_W-1:0] rs_data,
  output logic [DATA_W-1:0] rt_data,
  output logic [DATA_W-1:0] jr_data
);
  localparam int NPORT = 3;

  logic [DATA_W-1:0]          wb_val;
  logic [NUM_REGS*DATA_W-1:0] flat_q;
  logic [IDX_W-1:0]           port_idx [NPORT];
  logic [DATA_W-1:0]          port_dat [NPORT];
  logic                       port_fwd [NPORT];

  rf_wb_mux #(.DATA_W(DATA_W)) u_wb_mux (
    .sel_load (wb_sel_load),
    .alu_val  (wb_alu),
    .load_val (wb_load),
    .wb_val   (wb_val)
  );

  rf_storage #(
    .NUM_REGS (NUM_REGS), .DATA_W (DATA_W),
    .LINK_IDX (LINK_IDX), .LINK_RST (LINK_RST),
    .STACK_IDX(STACK_IDX), .MEM_SIZE (MEM_SIZE)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .we     (wb_we),
    .widx   (wb_idx),
    .wdata  (wb_val),
    .flat_q (flat_q)
  );

  assign port_idx[0] = rs_idx;
  assign port_idx[1] = rt_idx;
  assign port_idx[2] = jr_idx;

  // Only the jump-target port (last) sees the memory-stage result.
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    if (p == NPORT - 1) begin : g_jump
      assign port_fwd[p] = mem_fwd_en && (mem_idx == port_idx[p]);
    end else begin : g_oper
      assign port_fwd[p] = 1'b0;
    end
    rf_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd (
      .flat_q  (flat_q),
      .ridx    (port_idx[p]),
      .wb_we   (wb_we),
      .wb_idx  (wb_idx),
      .wb_val  (wb_val),
      .fwd_hit (port_fwd[p]),
      .fwd_val (mem_alu),
      .rdata   (port_dat[p])
    );
  end

  assign rs_data = port_dat[0];
  assign rt_data = port_dat[1];
  assign jr_data = port_dat[2];
endmodule

// File: rtl/bypass_regfile_chk.sv
module bypass_regfile_chk #(
  parameter int          NUM_REGS  = 32,
  parameter int          DATA_W    = 32,
  parameter int          LINK_IDX  = 31,
  parameter logic [31:0] LINK_RST  = 32'hDEADBEEF,
  localparam int         IDX_W     = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_we,
  input logic [IDX_W-1:0]  wb_idx,
  input logic              wb_sel_load,
  input logic [DATA_W-1:0] wb_alu,
  input logic [DATA_W-1:0] wb_load,
  input logic              mem_fwd_en,
  input logic [IDX_W-1:0]  mem_idx,
  input logic [DATA_W-1:0] mem_alu,
  input logic [IDX_W-1:0]  rs_idx,
  input logic [IDX_W-1:0]  rt_idx,
  input logic [IDX_W-1:0]  jr_idx,
  input logic [DATA_W-1:0] rs_data,
  input logic [DATA_W-1:0] rt_data,
  input logic [DATA_W-1:0] jr_data
);
  logic [DATA_W-1:0] exp_wb;
  logic              armed;
  logic              mem_hit;

  always_comb begin
    exp_wb  = wb_sel_load ? wb_load : wb_alu;
    mem_hit = mem_fwd_en && (mem_idx == jr_idx);
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  AST_RS_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst || !armed)
    (wb_we && rs_idx == wb_idx) |-> rs_data == exp_wb); // R5
  AST_RT_SAME_CYCLE: assert property (@(posedge clk) disable iff (rst || !armed)
    (wb_we && rt_idx == wb_idx) |-> rt_data == exp_wb); // R6
  AST_JR_WB_PATH: assert property (@(posedge clk) disable iff (rst || !armed)
    (wb_we && jr_idx == wb_idx && !mem_hit) |-> jr_data == exp_wb); // R7
  AST_JR_MEM_PATH: assert property (@(posedge clk) disable iff (rst || !armed)
    mem_hit |-> jr_data == mem_alu); // R8
  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst || !armed)
    (wb_we && !$past(rst)) |=> ((rs_idx != $past(wb_idx)) || (wb_we && wb_idx == rs_idx)
                   || rs_data == $past(exp_wb))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
    (!wb_we && !$past(rst)) |=> ((rs_idx != $past(rs_idx)) || (wb_we && wb_idx == rs_idx)
                   || $stable(rs_data))); // R4
  AST_LINK_RESET: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(rst) && !(wb_we && wb_idx == rs_idx) && rs_idx == IDX_W'(LINK_IDX))
      |-> rs_data == LINK_RST[DATA_W-1:0]); // R1
endmodule

bind bypass_regfile bypass_regfile_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .LINK_IDX(LINK_IDX), .LINK_RST(LINK_RST)
) u_chk (.*);

// File: tb/tb_bypass_regfile.sv
module tb_bypass_regfile;
  localparam logic [31:0] MEMSZ = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_we = 1'b0, wb_sel_load = 1'b0, mem_fwd_en = 1'b0;
  logic [4:0]  wb_idx = '0, mem_idx = '0, rs_idx = '0, rt_idx = '0, jr_idx = '0;
  logic [31:0] wb_alu = '0, wb_load = '0, mem_alu = '0;
  logic [31:0] rs_data, rt_data, jr_data;

  logic [31:0] model [32];
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  bypass_regfile #(.MEM_SIZE(MEMSZ)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat_alu(input int i);
    return (32'(i) * 32'h0101_0101) ^ 32'hA500_0000;
  endfunction
  function automatic logic [31:0] pat_ld(input int i);
    return (32'(i) * 32'h0011_0203) ^ 32'h5A00_00FF;
  endfunction

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = (i == 31) ? 32'hDEADBEEF : (i == 29) ? MEMSZ : 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset contents, R11 combinational index changes
    for (int i = 0; i < 32; i++) begin
      rs_idx = 5'(i); rt_idx = 5'(31 - i); jr_idx = 5'(i);
      #1;
      chk("R1 rs", rs_data, model[i]);
      chk("R1 rt R11", rt_data, model[31 - i]);
      chk("R1 jr", jr_data, model[i]);
    end

    // Write every index with same-cycle reads: R2 R3 R5 R6 R7
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      wb_we = 1'b1; wb_idx = 5'(i); wb_sel_load = i[0];
      wb_alu = pat_alu(i); wb_load = pat_ld(i);
      rs_idx = 5'(i); rt_idx = 5'(i); jr_idx = 5'(i);
      #1;
      model[i] = i[0] ? pat_ld(i) : pat_alu(i);
      chk("R5 R3 rs bypass", rs_data, model[i]);
      chk("R6 rt bypass", rt_data, model[i]);
      chk("R7 jr bypass", jr_data, model[i]);
    end
    @(negedge clk);
    wb_we = 1'b0;
    for (int i = 0; i < 32; i++) begin
      rs_idx = 5'(i); rt_idx = 5'((i + 7) % 32); jr_idx = 5'((i + 13) % 32);
      #1;
      chk("R2 R3 rs stored", rs_data, model[i]);
      chk("R2 rt stored", rt_data, model[(i + 7) % 32]);
      chk("R2 jr stored", jr_data, model[(i + 13) % 32]);
    end

    // R4 disabled write does nothing
    @(negedge clk);
    wb_we = 1'b0; wb_idx = 5'd5; wb_alu = 32'hFFFF_0000; wb_load = 32'h0000_FFFF;
    rs_idx = 5'd5; rt_idx = 5'd5; jr_idx = 5'd5;
    #1;
    chk("R4 rs same cycle", rs_data, model[5]);
    @(negedge clk); #1;
    chk("R4 rs after edge", rs_data, model[5]);
    chk("R4 jr after edge", jr_data, model[5]);

    // R8 memory-stage path on jump port, R10 not on operand ports
    @(negedge clk);
    mem_fwd_en = 1'b1; mem_idx = 5'd7; mem_alu = 32'h1234_5678;
    rs_idx = 5'd7; rt_idx = 5'd7; jr_idx = 5'd7;
    #1;
    chk("R8 jr mem path", jr_data, 32'h1234_5678);
    chk("R10 rs ignores mem", rs_data, model[7]);
    chk("R10 rt ignores mem", rt_data, model[7]);
    jr_idx = 5'd8; #1;
    chk("R8 jr no match", jr_data, model[8]);

    // R9 both paths match: memory stage wins
    @(negedge clk);
    wb_we = 1'b1; wb_idx = 5'd7; wb_sel_load = 1'b0; wb_alu = 32'hCAFE_0007;
    jr_idx = 5'd7; rs_idx = 5'd7;
    #1;
    chk("R9 jr younger wins", jr_data, 32'h1234_5678);
    chk("R5 rs wb with mem", rs_data, 32'hCAFE_0007);
    model[7] = 32'hCAFE_0007;

    // R7 with memory path off, register zero writable (R2)
    @(negedge clk);
    mem_fwd_en = 1'b0; wb_idx = 5'd0; wb_sel_load = 1'b1; wb_load = 32'h0BAD_F00D;
    jr_idx = 5'd0;
    #1;
    chk("R7 jr wb only", jr_data, 32'h0BAD_F00D);
    model[0] = 32'h0BAD_F00D;
    @(negedge clk);
    wb_we = 1'b0; rs_idx = 5'd0; rt_idx = 5'd7;
    #1;
    chk("R2 reg zero written", rs_data, model[0]);
    chk("R2 reg7 written", rt_data, model[7]);

    // R1 reset again restores specials
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rs_idx = 5'd31; rt_idx = 5'd29; jr_idx = 5'd7;
    #1;
    chk("R1 link after reset", rs_data, 32'hDEADBEEF);
    chk("R1 stack after reset", rt_data, MEMSZ);
    chk("R1 other after reset", jr_data, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule